// File: doc/BRIEF.md
# Cascadable Interval Timer with Square-Wave Output

This block is a programmable interval timer built from two byte-wide counters. It runs either as a single 8-bit timer or as a 16-bit timer with the upper counter chained to the lower one. A count clock is picked from three taps of a prescaler running at the instruction-cycle rate, or from an external clock pin. The counter climbs from zero to a programmed limit. On reaching the limit it restarts at once, raises a sticky interrupt flag and inverts a square-wave output.

Software configures the block through a narrow write port. A 2-bit selector picks one of four targets: the low limit byte, the high limit byte, the control byte, or the flag-clear strobe. An instruction cycle is modelled as one enable pulse every four system clocks.

Top module: `cascade_timer`

## Requirements
- R1: Write port map: `wrSel`=0 loads the low limit byte, 1 loads the high limit byte, 2 loads control (bit0 run, bit1 16-bit mode, bits3:2 clock code), and 3 is the flag-clear strobe. Writes take effect on the clock edge where `wrEn` is high.
- R2: Clock code 0, 1 and 2 give one count tick every 2, 32 and 512 instruction cycles respectively, where one instruction cycle is 4 system clocks. Code 3 selects the external clock.
- R3: For a limit value N, the interval between matches is N+1 count ticks. N=0 gives a one-tick interval.
- R4: In 8-bit mode only the low limit byte is compared, so the interval spans 1 to 256 ticks and the high byte has no effect.
- R5: In 16-bit mode the high counter advances only when the low counter wraps. A match needs both bytes equal to their limit bytes, so the interval spans 1 to 65536 ticks.
- R6: The square-wave output inverts on every match. With a constant limit it runs without a gap, so its period is two intervals.
- R7: In external mode, each rising edge of `extClk` (after a two-flop synchronizer) is one tick. The pin must toggle slower than half the system clock.
- R8: A match sets `irqFlag`. The flag stays set until a flag-clear write with data bit0 = 1. A flag-clear write with bit0 = 0 leaves it set.
- R9: After reset the timer is stopped, and `toggleOut` and `irqFlag` are 0. Clearing the run bit resets the counter and the prescaler, and `toggleOut` holds its level. On restart the first match comes a full interval after the run write.
- R10: A limit written while running takes effect only after the next match, so the interval in progress completes with the old limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target select |
| wrData | input | 8 | Write data |
| extClk | input | 1 | External count clock |
| irqFlag | output | 1 | Sticky interval-match flag |
| toggleOut | output | 1 | Square-wave output |

## Verification
The hardest case to reach from the ports is a limit rewrite that lands in the middle of a running interval. The write must be held back until the match, yet still apply to the very next interval. The stimulus first synchronizes to an output edge, then waits part of an interval before writing a shorter limit. It then measures two consecutive half-periods: the first must use the old length and the second the new one. A 16-bit limit whose low byte sits below the wrap point makes the high counter advance through carry before the match, and an 8-bit run with a non-zero high byte shows that the upper byte is ignored.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  typedef enum logic [1:0] {
    CS_DIV2   = 2'd0,
    CS_DIV32  = 2'd1,
    CS_DIV512 = 2'd2,
    CS_EXT    = 2'd3
  } clkSel_e;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_FLAG = 2'd3
  } wrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic halt;
    logic wide;
    logic clrFlag;
  } strb_t;
endpackage

// File: rtl/ctimer_ctrl.sv
module ctimer_ctrl
  import ctimer_pkg::*;
#(
  parameter int W        = 8,
  parameter int INST_DIV = 4,
  parameter int DIV_A    = 2,
  parameter int DIV_B    = 32,
  parameter int DIV_C    = 512
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [1:0]     wrSel,
  input  logic [W-1:0]   wrData,
  input  logic           extClk,
  output strb_t          strb,
  output logic [2*W-1:0] shadowLim,
  output logic           running
);
  localparam int IW = (INST_DIV > 1) ? $clog2(INST_DIV) : 1;
  localparam int PW = (DIV_C > 1) ? $clog2(DIV_C) : 1;
  localparam logic [IW-1:0] INST_LAST = IW'(INST_DIV - 1);

  logic          wideReg;
  clkSel_e       clkSel;
  logic [IW-1:0] instCnt;
  logic [PW-1:0] preCnt;
  logic [PW-1:0] preLast;
  logic [2:0]    extSync;
  logic          instEn, preWrap, extRise, tickInt, tickExt;

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      wideReg   <= 1'b0;
      clkSel    <= CS_DIV2;
      shadowLim <= '0;
    end else if (wrEn) begin
      unique case (wrSel_e'(wrSel))
        SEL_LO:   shadowLim[W-1:0]   <= wrData;
        SEL_HI:   shadowLim[2*W-1:W] <= wrData;
        SEL_CTRL: begin
          running <= wrData[0];
          wideReg <= wrData[1];
          clkSel  <= clkSel_e'(wrData[3:2]);
        end
        default: ;
      endcase
    end
  end

  // prescaler tap selection
  always_comb begin
    unique case (clkSel)
      CS_DIV2:   preLast = PW'(DIV_A - 1);
      CS_DIV32:  preLast = PW'(DIV_B - 1);
      default:   preLast = PW'(DIV_C - 1);
    endcase
  end

  assign instEn  = running && (instCnt == INST_LAST);
  assign preWrap = (preCnt >= preLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instCnt <= '0;
      preCnt  <= '0;
    end else if (!running) begin
      instCnt <= '0;
      preCnt  <= '0;
    end else begin
      instCnt <= instEn ? '0 : instCnt + 1'b1;
      if (instEn) preCnt <= preWrap ? '0 : preCnt + 1'b1;
    end
  end

  // external clock synchronizer and edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[1:0], extClk};
  end

  assign extRise = extSync[1] && !extSync[2];
  assign tickInt = instEn && preWrap && (clkSel != CS_EXT);
  assign tickExt = running && extRise && (clkSel == CS_EXT);

  assign strb.tick    = tickInt || tickExt;
  assign strb.halt    = !running;
  assign strb.wide    = wideReg;
  assign strb.clrFlag = wrEn && (wrSel_e'(wrSel) == SEL_FLAG) && wrData[0];
endmodule

// File: rtl/ctimer_dp.sv
module ctimer_dp
  import ctimer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  strb_t          strb,
  input  logic [2*W-1:0] shadowLim,
  output logic [W-1:0]   cntLo,
  output logic [W-1:0]   cntHi,
  output logic           hit,
  output logic           irqFlag,
  output logic           toggleOut
);
  localparam int NB = 2;

  logic [NB*W-1:0] cnt;
  logic [NB*W-1:0] lim;
  logic [NB-1:0]   byteEq;

  for (genvar i = 0; i < NB; i++) begin : g_cmp
    assign byteEq[i] = (cnt[i*W +: W] == lim[i*W +: W]);
  end

  assign hit   = strb.tick && !strb.halt && byteEq[0] && (byteEq[1] || !strb.wide);
  assign cntLo = cnt[W-1:0];
  assign cntHi = cnt[2*W-1:W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      lim       <= '0;
      toggleOut <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      if (strb.halt) begin
        cnt <= '0;
        lim <= shadowLim;
      end else if (hit) begin
        cnt       <= '0;
        lim       <= shadowLim;
        toggleOut <= !toggleOut;
      end else if (strb.tick) begin
        cnt[W-1:0] <= cnt[W-1:0] + 1'b1;
        if (strb.wide && (&cnt[W-1:0])) cnt[2*W-1:W] <= cnt[2*W-1:W] + 1'b1;
      end
      if (!strb.wide) cnt[2*W-1:W] <= '0;
      if (hit)               irqFlag <= 1'b1;
      else if (strb.clrFlag) irqFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import ctimer_pkg::*;
#(
  parameter int W        = 8,
  parameter int INST_DIV = 4,
  parameter int DIV_A    = 2,
  parameter int DIV_B    = 32,
  parameter int DIV_C    = 512
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrSel,
  input  logic [W-1:0] wrData,
  input  logic         extClk,
  output logic         irqFlag,
  output logic         toggleOut
);
  strb_t          strb;
  logic [2*W-1:0] shadowLim;
  logic           running;
  logic           wide;
  logic [W-1:0]   cntLo, cntHi;
  logic           hit;

  assign wide = strb.wide;

  ctimer_ctrl #(.W(W), .INST_DIV(INST_DIV), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .extClk(extClk), .strb(strb), .shadowLim(shadowLim), .running(running)
  );

  ctimer_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .shadowLim(shadowLim),
    .cntLo(cntLo), .cntHi(cntHi), .hit(hit), .irqFlag(irqFlag), .toggleOut(toggleOut)
  );
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         wrEn,
  input logic [1:0]   wrSel,
  input logic [W-1:0] wrData,
  input logic         irqFlag,
  input logic         toggleOut,
  input logic         running,
  input logic         wide,
  input logic [W-1:0] cntLo,
  input logic [W-1:0] cntHi,
  input logic         hit
);
  // R6
  toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(toggleOut) |-> $past(hit));

  // R3
  restart_after_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (cntLo == '0) && (cntHi == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !(wrEn && wrSel == 2'd3 && wrData[0]) |=> irqFlag);

  // R8
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(hit));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> $stable(toggleOut) && (cntLo == '0) && (cntHi == '0));

  // R4
  narrow_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wide |=> (cntHi == '0));
endmodule

bind cascade_timer cascade_timer_chk #(.W(W)) u_chk (.*);

// File: tb/cascade_timer_tb.sv
`timescale 1ns/1ps
module cascade_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       extClk = 1'b0;
  logic       irqFlag, toggleOut;

  int    total = 0;
  int    bad = 0;
  longint cyc = 0;
  localparam int EXT_PER = 6;

  cascade_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .extClk(extClk), .irqFlag(irqFlag), .toggleOut(toggleOut)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      repeat (EXT_PER / 2) @(negedge clk);
      extClk = ~extClk;
    end
  end

  function automatic longint expPeriod(input int n, input int sel);
    int div;
    case (sel)
      0: div = 2;
      1: div = 32;
      2: div = 512;
      default: div = 0;
    endcase
    if (sel == 3) return longint'(n + 1) * EXT_PER;
    return longint'(n + 1) * div * 4;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTog(output longint t, output bit ok);
    logic lvl;
    lvl = toggleOut;
    ok = 1'b0;
    t = cyc;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (toggleOut !== lvl) begin
        ok = 1'b1;
        t = cyc;
        break;
      end
    end
  endtask

  task automatic setup(input int lim, input bit wide, input int sel);
    wr(2'd2, {4'd0, 2'(sel), wide, 1'b0});
    wr(2'd0, lim[7:0]);
    wr(2'd1, lim[15:8]);
    wr(2'd2, {4'd0, 2'(sel), wide, 1'b1});
  endtask

  task automatic measure(input longint exp, input string req);
    longint t0, t1;
    bit ok0, ok1;
    waitTog(t0, ok0);
    waitTog(t1, ok1);
    check(ok0 && ok1 && (t1 - t0 == exp), req, t1 - t0, exp);
  endtask

  initial begin
    #(4ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint t0, t1, t2;
    bit ok0, ok1;
    logic lvl;
    bit stable;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9 reset state
    check(toggleOut == 1'b0, "R9 reset toggle", toggleOut, 0);
    check(irqFlag == 1'b0, "R9 reset flag", irqFlag, 0);

    // R3, R6: 8-bit N=3, code 0, two consecutive half-periods
    setup(3, 1'b0, 0);
    measure(expPeriod(3, 0), "R3 N=3 div2");
    measure(expPeriod(3, 0), "R6 continuous");
    check(irqFlag == 1'b1, "R8 flag set on match", irqFlag, 1);

    // R9 stop holds toggle, no new matches
    wr(2'd2, 8'h00);
    lvl = toggleOut;
    stable = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (toggleOut !== lvl) stable = 1'b0;
    end
    check(stable, "R9 toggle holds when stopped", toggleOut, lvl);

    // R8 clear semantics (timer stopped)
    wr(2'd3, 8'h00);
    check(irqFlag == 1'b1, "R8 write 0 keeps flag", irqFlag, 1);
    wr(2'd3, 8'h01);
    check(irqFlag == 1'b0, "R8 write 1 clears flag", irqFlag, 0);

    // R3 N=0, R4 max and high byte ignored
    setup(0, 1'b0, 0);
    measure(expPeriod(0, 0), "R3 N=0 one tick");
    setup(255, 1'b0, 0);
    measure(expPeriod(255, 0), "R4 N=255");
    setup(16'h1203, 1'b0, 0);
    measure(expPeriod(3, 0), "R4 high byte ignored");

    // R2 other prescaler taps, R1 control field
    setup(2, 1'b0, 1);
    measure(expPeriod(2, 1), "R2 div32");
    setup(0, 1'b0, 2);
    measure(expPeriod(0, 2), "R2 div512");

    // R5 cascade
    setup(16'h0100, 1'b1, 0);
    measure(expPeriod(16'h0100, 0), "R5 N=0x0100");
    setup(16'h0203, 1'b1, 0);
    measure(expPeriod(16'h0203, 0), "R5 N=0x0203");

    // R7 external clock
    setup(4, 1'b0, 3);
    measure(expPeriod(4, 3), "R7 ext 8-bit");
    setup(16'h0101, 1'b1, 3);
    measure(expPeriod(16'h0101, 3), "R7 ext 16-bit");

    // R10 deferred limit
    setup(15, 1'b0, 0);
    waitTog(t0, ok0);
    repeat (20) @(negedge clk);
    wr(2'd0, 8'd3);
    waitTog(t1, ok1);
    check(ok0 && ok1 && (t1 - t0 == expPeriod(15, 0)), "R10 old interval completes", t1 - t0, expPeriod(15, 0));
    waitTog(t2, ok0);
    check(ok0 && (t2 - t1 == expPeriod(3, 0)), "R10 new interval used", t2 - t1, expPeriod(3, 0));

    // R9 restart latency: full interval after run write
    wr(2'd2, 8'h00);
    wr(2'd0, 8'd4);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'h01);
    t0 = cyc;
    waitTog(t1, ok0);
    check(ok0 && (t1 - t0 >= expPeriod(4, 0) - 1) && (t1 - t0 <= expPeriod(4, 0) + 1),
          "R9 restart full interval", t1 - t0, expPeriod(4, 0));

    // random mix: R3 with codes 0/1, both widths
    for (int k = 0; k < 10; k++) begin
      int n, sel;
      bit w;
      n = int'($urandom % 16);
      sel = int'($urandom % 2);
      w = 1'($urandom % 2);
      setup(n, w, sel);
      measure(expPeriod(n, sel), "R3 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule